// File: doc/BRIEF.md
# Bit-wise Pattern Match Detector

The detector watches an 8-bit input port and raises a sticky match flag when the port satisfies a programmed pattern. Each bit is given one of six behaviours: ignored, any change, low level, high level, falling edge or rising edge. A per-bit invert mask is applied to the raw port before any matching. The per-bit results are combined under one of four combine modes: off, all-of, any-of, or any-of with priority. The block also keeps a captured data byte and produces a one-cycle event pulse.

Each clock, the port is sampled into a current register, and the previous sample is kept for edge detection. A captured data register follows the current sample. In latch mode it freezes on the matching byte until software clears the flag. The event pulse fires on every match. It also fires on every change of the captured byte, unless match-only events are selected.

The control FSM has three states. WARM waits for two valid samples. WATCH arms the detector. HELD means the flag is set. The transitions are:
- WARM→WATCH once history is valid.
- WARM→HELD or WATCH→HELD on an accepted match.
- HELD→WATCH on clear.

Top module: `pm_detector`

## Requirements
- R1: After reset, match_flag, data_out and match_event are all 0.
- R2: Every bit of cfg_invert set to 1 inverts that port bit before matching. The inverted value is the one that reaches data_out.
- R3: With mask=1 and transition=0 a bit matches a level: polarity 0 matches low and polarity 1 matches high.
- R4: With mask=1 and transition=1 a bit matches an edge between the previous and the current sample: polarity 0 matches a falling edge and polarity 1 matches a rising edge.
- R5: With mask=0 and transition=1 a bit matches any change between samples. With mask=0 and transition=0 the bit is ignored.
- R6: cfg_mode encoding is 0=off, 1=all-of, 2=any-of, 3=priority. In mode 0 no match is ever flagged.
- R7: In mode 1 a match needs every specified bit to be satisfied in the same cycle. If no bit is specified, nothing matches.
- R8: In mode 2 a match needs at least one specified bit to be satisfied.
- R9: In mode 3 a match is accepted only when the highest satisfied bit index is above the index stored by the previous accepted match. Clearing the flag empties the stored index.
- R10: match_flag stays set until clr_match. A clear in the same cycle as a match wins, and that match is dropped.
- R11: With cfg_latch=1, data_out freezes at the matching byte until the clear. With cfg_latch=0 it follows each sample.
- R12: match_event pulses for every accepted match. With cfg_match_only=0 it also pulses whenever data_out takes a new value.
- R13: A port value driven before clock edge n affects the outputs from clock edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | 8 | Raw input port |
| cfg_invert | input | 8 | Per-bit input inversion |
| cfg_mask | input | 8 | Per-bit mask term |
| cfg_trans | input | 8 | Per-bit transition term |
| cfg_pol | input | 8 | Per-bit polarity term |
| cfg_mode | input | 2 | Combine mode |
| cfg_latch | input | 1 | Freeze data on match |
| cfg_match_only | input | 1 | Events only on matches |
| clr_match | input | 1 | Clear flag, stored index and freeze |
| match_flag | output | 1 | Sticky match flag |
| data_out | output | 8 | Captured (inverted) data byte |
| match_event | output | 1 | One-cycle event pulse |

## Verification
The bench targets several failure modes:
- Edge terms against the previous sample: a design comparing against a stale or reset value would miss or invent edges.
- An all-of pattern that needs a level and an edge in the same cycle: an OR-like reduction would flag early.
- The priority mode's stored index: it must reject equal or lower bits and forget them after a clear, or repeated bits would refire.
- A clear that lands together with a match: it must win.
- A latched byte that must not move while the flag is held.
- Event pulses that must vanish for plain data updates when match-only events are chosen.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_ALL  = 2'd1,
        PM_ANY  = 2'd2,
        PM_PRIO = 2'd3
    } pm_mode_e;

    typedef enum logic [1:0] {
        ST_WARM  = 2'd0,
        ST_WATCH = 2'd1,
        ST_HELD  = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pm_sampler.sv
module pm_sampler #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_in,
    input  logic [WIDTH-1:0] invert,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev,
    output logic             hist_ok
);
    logic cur_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            prev    <= '0;
            cur_ok  <= 1'b0;
            hist_ok <= 1'b0;
        end else begin
            cur     <= port_in ^ invert;
            prev    <= cur;
            cur_ok  <= 1'b1;
            hist_ok <= cur_ok;
        end
    end
endmodule

// File: rtl/pm_bit_eval.sv
module pm_bit_eval #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] trans,
    input  logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] spec,
    output logic [WIDTH-1:0] bit_hit
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_comb begin
            spec[g] = mask[g] | trans[g];
            unique case ({mask[g], trans[g]})
                2'b00:   bit_hit[g] = 1'b0;
                2'b01:   bit_hit[g] = cur[g] ^ prev[g];
                2'b10:   bit_hit[g] = ~(cur[g] ^ pol[g]);
                default: bit_hit[g] = pol[g] ? (cur[g] & ~prev[g])
                                             : (~cur[g] & prev[g]);
            endcase
        end
    end
endmodule

// File: rtl/pm_combine.sv
module pm_combine
    import pm_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH + 1)
) (
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] spec,
    input  logic [WIDTH-1:0] bit_hit,
    input  logic [IDXW-1:0]  pri_q,
    input  logic             hist_ok,
    output logic [IDXW-1:0]  top_idx,
    output logic             hit
);
    logic [WIDTH-1:0] good;
    logic             raw;

    always_comb begin
        good    = bit_hit & spec;
        top_idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (good[i]) top_idx = IDXW'(i + 1);
        end
        unique case (pm_mode_e'(mode))
            PM_OFF:  raw = 1'b0;
            PM_ALL:  raw = (|spec) && (&(bit_hit | ~spec));
            PM_ANY:  raw = |good;
            PM_PRIO: raw = top_idx > pri_q;
            default: raw = 1'b0;
        endcase
        hit = raw && hist_ok;
    end
endmodule

// File: rtl/pm_detector.sv
module pm_detector
    import pm_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_in,
    input  logic [WIDTH-1:0] cfg_invert,
    input  logic [WIDTH-1:0] cfg_mask,
    input  logic [WIDTH-1:0] cfg_trans,
    input  logic [WIDTH-1:0] cfg_pol,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_latch,
    input  logic             cfg_match_only,
    input  logic             clr_match,
    output logic             match_flag,
    output logic [WIDTH-1:0] data_out,
    output logic             match_event
);
    logic [WIDTH-1:0] s_cur, s_prev, spec, bit_hit, data_nx;
    logic             hist_ok, hit, take, frozen;
    logic [IDXW-1:0]  top_idx, pri_q;
    pm_state_e        state_q, state_d;

    pm_sampler #(.WIDTH(WIDTH)) u_smp (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .invert(cfg_invert),
        .cur(s_cur), .prev(s_prev), .hist_ok(hist_ok)
    );

    pm_bit_eval #(.WIDTH(WIDTH)) u_bits (
        .cur(s_cur), .prev(s_prev), .mask(cfg_mask), .trans(cfg_trans),
        .pol(cfg_pol), .spec(spec), .bit_hit(bit_hit)
    );

    pm_combine #(.WIDTH(WIDTH)) u_comb (
        .mode(cfg_mode), .spec(spec), .bit_hit(bit_hit), .pri_q(pri_q),
        .hist_ok(hist_ok), .top_idx(top_idx), .hit(hit)
    );

    assign take = hit && !clr_match;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WARM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM:  if (take) state_d = ST_HELD;
                      else if (hist_ok) state_d = ST_WATCH;
            ST_WATCH: if (take) state_d = ST_HELD;
            ST_HELD:  if (clr_match) state_d = ST_WATCH;
            default:  state_d = ST_WARM;
        endcase
    end

    // outputs
    assign match_flag = (state_q == ST_HELD);
    assign frozen     = match_flag && cfg_latch && !clr_match;
    assign data_nx    = frozen ? data_out : s_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out    <= '0;
            match_event <= 1'b0;
            pri_q       <= '0;
        end else begin
            data_out    <= data_nx;
            match_event <= take || (!cfg_match_only && (data_nx != data_out));
            if (clr_match)
                pri_q <= '0;
            else if (take && pm_mode_e'(cfg_mode) == PM_PRIO)
                pri_q <= top_idx;
        end
    end

    // R10: flag held until cleared
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !clr_match) |=> match_flag);
    // R10: clear wins
    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_match |=> !match_flag);
    // R6: off mode never raises the flag
    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_flag && cfg_mode == 2'd0) |=> !match_flag);
    // R11: latched byte holds
    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && cfg_latch && !clr_match) |=> $stable(data_out));
    // R12: match-only events come with the flag
    p_match_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_match_only && !clr_match) |=> (!match_event || match_flag));
endmodule

// File: tb/tb_pm_detector.sv
`timescale 1ns/1ps
module tb_pm_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_in = '0, cfg_invert = '0, cfg_mask = '0, cfg_trans = '0, cfg_pol = '0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_latch = 1'b0, cfg_match_only = 1'b0, clr_match = 1'b0;
    logic       match_flag, match_event;
    logic [7:0] data_out;

    int total = 0, bad = 0;
    bit done = 0, ended = 0;

    always #2.5 clk = ~clk;

    pm_detector dut (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .cfg_invert(cfg_invert),
        .cfg_mask(cfg_mask), .cfg_trans(cfg_trans), .cfg_pol(cfg_pol),
        .cfg_mode(cfg_mode), .cfg_latch(cfg_latch), .cfg_match_only(cfg_match_only),
        .clr_match(clr_match), .match_flag(match_flag), .data_out(data_out),
        .match_event(match_event)
    );

    // reference state, built from the requirements
    logic [7:0] m_cur = '0, m_prev = '0, m_data = '0;
    logic       m_vc = 0, m_vp = 0, m_flag = 0;
    int         m_pri = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    // driver: sets inputs for the next edge and pushes the expected result
    task automatic step(input logic [7:0] p, input logic c, input string tag);
        logic [7:0] spec, bm, dnx;
        int top;
        logic hit, take, ev, frz;
        port_in   = p;
        clr_match = c;
        top = 0;
        for (int i = 0; i < 8; i++) begin
            spec[i] = cfg_mask[i] | cfg_trans[i];
            if (!cfg_mask[i]) bm[i] = cfg_trans[i] & (m_cur[i] != m_prev[i]);
            else if (!cfg_trans[i]) bm[i] = (m_cur[i] == cfg_pol[i]);
            else if (cfg_pol[i]) bm[i] = m_cur[i] & ~m_prev[i];
            else bm[i] = ~m_cur[i] & m_prev[i];
            if (spec[i] && bm[i]) top = i + 1;
        end
        case (cfg_mode)
            2'd1:    hit = (spec != 0) && ((bm | ~spec) == 8'hFF);
            2'd2:    hit = (bm & spec) != 0;
            2'd3:    hit = top > m_pri;
            default: hit = 0;
        endcase
        hit  = hit && m_vp;
        take = hit && !c;
        frz  = m_flag && cfg_latch && !c;
        dnx  = frz ? m_data : m_cur;
        ev   = take || (!cfg_match_only && (dnx != m_data));
        if (c) begin
            m_flag = 0; m_pri = 0;
        end else if (take) begin
            m_flag = 1;
            if (cfg_mode == 2'd3) m_pri = top;
        end
        m_data = dnx;
        m_prev = m_cur; m_cur = p ^ cfg_invert;
        m_vp = m_vc; m_vc = 1;
        exp_q.push_back({m_flag, m_data, ev});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compares after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({match_flag, data_out, match_event} !== e) begin
                    bad++;
                    $display("FAIL %s (R13 timing): flag/data/event actual=%b/%h/%b expected=%b/%h/%b",
                             t, match_flag, data_out, match_event, e[9], e[8:1], e[0]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if ({match_flag, data_out, match_event} !== 10'b0) begin
            bad++;
            $display("FAIL R1: actual=%b/%h/%b expected=0/00/0", match_flag, data_out, match_event);
        end
        rst_n = 1'b1;
        // R6 off mode, R12 update events, R11 data follows
        step(8'h00, 0, "R6"); step(8'h5A, 0, "R6"); step(8'h5A, 0, "R12");
        step(8'hFF, 0, "R11"); step(8'hFF, 0, "R6");
        // R2 inversion with R3 high level, R8 any-of
        cfg_mode = 2'd2; cfg_mask = 8'h01; cfg_pol = 8'h01; cfg_invert = 8'h01;
        step(8'h01, 0, "R2"); step(8'h01, 0, "R2"); step(8'h00, 0, "R2");
        step(8'h00, 0, "R8"); step(8'h00, 1, "R10");
        // R3 low level
        cfg_invert = 8'h00; cfg_pol = 8'h00;
        step(8'h01, 0, "R3"); step(8'h01, 0, "R3"); step(8'h00, 0, "R3");
        step(8'h00, 0, "R3"); step(8'h01, 1, "R10"); step(8'h01, 0, "R3");
        // R4 rising then falling
        cfg_mask = 8'h08; cfg_trans = 8'h08; cfg_pol = 8'h08;
        step(8'h00, 0, "R4"); step(8'h00, 0, "R4"); step(8'h08, 0, "R4");
        step(8'h08, 0, "R4"); step(8'h00, 0, "R4"); step(8'h00, 1, "R4");
        cfg_pol = 8'h00;
        step(8'h08, 0, "R4"); step(8'h08, 0, "R4"); step(8'h00, 0, "R4");
        step(8'h00, 0, "R4"); step(8'h00, 1, "R4");
        // R5 any change on bit4, bit6 ignored
        cfg_mask = 8'h00; cfg_trans = 8'h10; cfg_pol = 8'h00;
        step(8'h40, 0, "R5"); step(8'h00, 0, "R5"); step(8'h00, 0, "R5");
        step(8'h10, 0, "R5"); step(8'h10, 0, "R5"); step(8'h10, 1, "R5");
        // R7 all-of: bit1 high and bit2 rising together
        cfg_mode = 2'd1; cfg_mask = 8'h06; cfg_trans = 8'h04; cfg_pol = 8'h06;
        step(8'h00, 0, "R7"); step(8'h02, 0, "R7"); step(8'h06, 0, "R7");
        step(8'h06, 0, "R7"); step(8'h06, 1, "R7"); step(8'h04, 0, "R7");
        step(8'h00, 0, "R7"); step(8'h04, 0, "R7"); step(8'h04, 0, "R7");
        cfg_mask = 8'h00; cfg_trans = 8'h00;
        step(8'hAA, 0, "R7"); step(8'h55, 0, "R7"); step(8'h55, 0, "R7");
        // R9 priority on bits 2 and 5 high
        cfg_mode = 2'd3; cfg_mask = 8'h24; cfg_pol = 8'h24;
        step(8'h00, 0, "R9"); step(8'h04, 0, "R9"); step(8'h04, 0, "R9");
        step(8'h24, 0, "R9"); step(8'h04, 0, "R9"); step(8'h24, 0, "R9");
        step(8'h04, 0, "R9"); step(8'h04, 1, "R9"); step(8'h04, 0, "R9");
        step(8'h04, 0, "R9"); step(8'h00, 1, "R9");
        // R10 clear against a simultaneous match
        cfg_mode = 2'd2; cfg_mask = 8'h01; cfg_pol = 8'h01;
        step(8'h01, 0, "R10"); step(8'h01, 0, "R10"); step(8'h01, 1, "R10");
        step(8'h01, 0, "R10"); step(8'h00, 1, "R10"); step(8'h00, 0, "R10");
        // R11 latch
        cfg_latch = 1'b1;
        step(8'h00, 0, "R11"); step(8'h81, 0, "R11"); step(8'h80, 0, "R11");
        step(8'h00, 0, "R11"); step(8'h00, 0, "R11"); step(8'h00, 1, "R11");
        step(8'h00, 0, "R11"); step(8'h00, 0, "R11");
        cfg_latch = 1'b0;
        // R12 match-only events
        cfg_match_only = 1'b1;
        step(8'h02, 0, "R12"); step(8'h03, 0, "R12"); step(8'h00, 0, "R12");
        step(8'h01, 0, "R12"); step(8'h01, 0, "R12"); step(8'h00, 1, "R12");
        step(8'h00, 0, "R12"); step(8'h00, 0, "R12");
        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule